// File: doc/BRIEF.md
# I2C EEPROM Random-Access Sequencer

This block turns a single command into the sequence of byte-level operations that an I2C EEPROM needs. The command gives a 7-bit device address, a memory address, a byte count and a direction. A configuration input picks one-byte or two-byte memory addressing. The sequencer does not drive the bus wires. It talks to a byte engine that performs one operation per request (start plus byte, send byte, receive byte, stop) and answers with a completion strobe that carries the acknowledge, a bus-error flag and the received byte.

For a write, the sequencer takes one byte from the write stream for each transaction. It runs a full transaction per byte and then advances the memory address. For a read, it first runs an address-only write transaction that ends in a stop. It then runs a separate read transaction and passes the received bytes to the read stream. It applies a fixed policy for missing acknowledges, bus errors and cancellation, and it closes every command with a one-cycle done pulse that carries pass or fail.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: `cmd_ready` is high only when the sequencer is idle. `busy` is high from command accept until the `done` pulse. `done` lasts one cycle and `done_ok` gives the result. A command with length 0 gets `done` with pass in the cycle after accept, and no engine request is issued.
- R2: The first byte of every transaction is `{dev, dir}`, where dir is 0 for a write transaction and 1 for a read transaction. With `addr_two`=1 the memory address is sent high byte first, then low byte. With `addr_two`=0 only the low byte is sent.
- R3: A write of N bytes runs N transactions. Each transaction takes exactly one write-stream byte before it starts and carries START, the address byte(s), SEND of the data byte and STOP. The memory address rises by one from each transaction to the next, and the carry runs into the high byte.
- R4: If the first byte of a write transaction gets no acknowledge, the sequencer issues STOP, waits `RETRY_DLY` cycles after the stop completes, and restarts that transaction. If the second attempt also gets no acknowledge, it issues STOP and reports fail.
- R5: If an address byte or data byte after the first gets no acknowledge, the sequencer issues STOP and reports fail at once. It does not retry and takes no further write-stream byte.
- R6: A read runs an address-only write transaction and a STOP. It then runs START `{dev,1}`, `len` RECV operations and a STOP. The last flag is set only on the final RECV, so for a single-byte read it is set on the first one. Each received byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in order.
- R7: If the first byte of the read transaction gets no acknowledge, the sequencer issues STOP and reports fail with no retry.
- R8: A bus error on any byte restarts the current transaction from START. It does not use up the retry budget. In a read transaction, the byte stream starts again from the first byte.
- R9: If `cancel` is high while the sequencer waits for a byte completion or a stop completion, the command ends with `done` and fail in the next cycle, and no further engine request is issued.
- R10: The engine opcodes are 0 for START (start condition plus send `eng_wdata`), 1 for SEND, 2 for RECV and 3 for STOP. At most one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when both are high |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | Device address |
| cmd_addr | input | 16 | Memory start address |
| cmd_len | input | LEN_W | Byte count |
| addr_two | input | 1 | 1 = two-byte memory addressing |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| cancel | input | 1 | Abort an ongoing wait |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished, one cycle |
| done_ok | output | 1 | Result valid with done, 1 = pass |
| eng_req | output | 1 | Engine operation request, one cycle |
| eng_op | output | 2 | Engine opcode |
| eng_wdata | output | 8 | Byte to send |
| eng_last | output | 1 | Final receive of the transaction |
| eng_done | input | 1 | Engine operation complete |
| eng_ack | input | 1 | Byte acknowledged |
| eng_berr | input | 1 | Bus error during operation |
| eng_rdata | input | 8 | Received byte |

## Verification
Writes and reads run over lengths 1 to 3 in both addressing modes. The start address sits just below a low-byte rollover, so that one-byte and two-byte framing can be told apart and a missing carry into the high byte shows up. Missing acknowledges are placed on the first attempt, on both attempts, on a data byte and on the read header. The engine log separates retry from immediate failure, and the measured gap before the restart checks the retry delay. Bus errors on a send and on a receive show that the transaction restarts without using the retry budget. A cancel during a wait, and zero-length commands, show that the sequencer stops cleanly with no extra engine traffic.

// File: rtl/eeprom_xfer_pkg.sv
package eeprom_xfer_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_STOP, S_STOPW, S_DELAY
  } seq_st_t;

  typedef enum logic [1:0] {
    AF_NEXT, AF_RETRY, AF_FAIL
  } after_t;

  // number of bytes in a write-direction transaction
  function automatic logic [2:0] tx_len(logic two, logic with_data);
    return 3'd2 + {2'b0, two} + {2'b0, with_data};
  endfunction

  // byte at position idx of a write-direction transaction
  function automatic logic [7:0] tx_byte(logic [2:0] idx, logic [6:0] dev,
                                         logic [15:0] addr, logic two,
                                         logic [7:0] dat);
    logic [2:0] j;
    j = two ? idx : idx + 3'd1;
    if (idx == 3'd0) return {dev, 1'b0};
    case (j)
      3'd1:    return addr[15:8];
      3'd2:    return addr[7:0];
      default: return dat;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_xfer_frame.sv
module eeprom_xfer_frame
  import eeprom_xfer_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             rd_phase,
  input  logic             in_stop,
  input  logic [LEN_W:0]   bidx,
  input  logic             two,
  input  logic [6:0]       dev,
  input  logic [15:0]      addr,
  input  logic [7:0]       dat,
  input  logic [LEN_W-1:0] len,
  output logic [1:0]       op,
  output logic [7:0]       wdata,
  output logic             last
);
  eng_op_t op_e;

  always_comb begin
    op_e  = OP_STOP;
    wdata = 8'd0;
    last  = 1'b0;
    if (!in_stop) begin
      if (bidx == '0) begin
        op_e  = OP_START;
        wdata = {dev, rd_phase};
      end else if (rd_phase) begin
        op_e = OP_RECV;
        last = (bidx == {1'b0, len});
      end else begin
        op_e  = OP_SEND;
        wdata = tx_byte(bidx[2:0], dev, addr, two, dat);
      end
    end
  end

  assign op = op_e;
endmodule

// File: rtl/eeprom_xfer_delay.sv
module eeprom_xfer_delay #(
  parameter int DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(DLY - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  p_expire_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !start |=> !expired);
endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
  import eeprom_xfer_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int RETRY_DLY = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_rd,
  input  logic [6:0]       cmd_dev,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             addr_two,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             cancel,
  output logic             busy,
  output logic             done,
  output logic             done_ok,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_wdata,
  output logic             eng_last,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic             eng_berr,
  input  logic [7:0]       eng_rdata
);
  localparam int BW = LEN_W + 1;

  seq_st_t          st;
  after_t           af;
  logic             rd_cmd, rd_phase, two_r, tried;
  logic [6:0]       dev_r;
  logic [15:0]      addr_r;
  logic [LEN_W-1:0] len_r, cnt_r;
  logic [BW-1:0]    bidx;
  logic [7:0]       dat_r;
  logic             dly_exp;

  // named events
  wire accept     = cmd_valid && cmd_ready;
  wire take_byte  = wr_valid && wr_ready;
  wire abort      = cancel && (st == S_WAIT || st == S_STOPW);
  wire retry_go   = (st == S_STOPW) && eng_done && (af == AF_RETRY);
  wire last_tx    = (bidx == BW'(tx_len(two_r, !rd_cmd) - 3'd1));
  wire last_rx    = (bidx == {1'b0, len_r});

  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign wr_ready  = (st == S_FETCH);
  assign eng_req   = (st == S_ISSUE) || (st == S_STOP);

  eeprom_xfer_frame #(.LEN_W(LEN_W)) u_frame (
    .rd_phase (rd_phase),
    .in_stop  (st == S_STOP),
    .bidx     (bidx),
    .two      (two_r),
    .dev      (dev_r),
    .addr     (addr_r),
    .dat      (dat_r),
    .len      (len_r),
    .op       (eng_op),
    .wdata    (eng_wdata),
    .last     (eng_last)
  );

  eeprom_xfer_delay #(.DLY(RETRY_DLY)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (retry_go),
    .expired (dly_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  af <= AF_NEXT;
      rd_cmd <= 1'b0; rd_phase <= 1'b0; two_r <= 1'b0; tried <= 1'b0;
      dev_r <= '0; addr_r <= '0; len_r <= '0; cnt_r <= '0;
      bidx <= '0; dat_r <= '0;
      done <= 1'b0; done_ok <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (abort) begin
        st <= S_IDLE; done <= 1'b1; done_ok <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            rd_cmd <= cmd_rd; two_r <= addr_two; dev_r <= cmd_dev;
            addr_r <= cmd_addr; len_r <= cmd_len; cnt_r <= cmd_len;
            rd_phase <= 1'b0; tried <= 1'b0; bidx <= '0;
            if (cmd_len == '0) begin
              done <= 1'b1; done_ok <= 1'b1;
            end else begin
              st <= cmd_rd ? S_ISSUE : S_FETCH;
            end
          end
          S_FETCH: if (take_byte) begin
            dat_r <= wr_data; bidx <= '0; tried <= 1'b0; st <= S_ISSUE;
          end
          S_ISSUE: st <= S_WAIT;
          S_WAIT: if (eng_done) begin
            if (eng_berr) begin
              bidx <= '0; st <= S_ISSUE;
            end else if (rd_phase) begin
              if (bidx == '0) begin
                if (!eng_ack) begin af <= AF_FAIL; st <= S_STOP; end
                else begin bidx <= bidx + 1'b1; st <= S_ISSUE; end
              end else begin
                rd_valid <= 1'b1; rd_data <= eng_rdata;
                if (last_rx) begin af <= AF_NEXT; st <= S_STOP; end
                else begin bidx <= bidx + 1'b1; st <= S_ISSUE; end
              end
            end else begin
              if (!eng_ack) begin
                af <= (bidx == '0 && !tried) ? AF_RETRY : AF_FAIL;
                st <= S_STOP;
              end else if (last_tx) begin
                af <= AF_NEXT; st <= S_STOP;
              end else begin
                bidx <= bidx + 1'b1; st <= S_ISSUE;
              end
            end
          end
          S_STOP: st <= S_STOPW;
          S_STOPW: if (eng_done) begin
            case (af)
              AF_FAIL: begin st <= S_IDLE; done <= 1'b1; done_ok <= 1'b0; end
              AF_RETRY: begin tried <= 1'b1; st <= S_DELAY; end
              default: begin
                if (rd_phase) begin
                  st <= S_IDLE; done <= 1'b1; done_ok <= 1'b1;
                end else if (rd_cmd) begin
                  rd_phase <= 1'b1; bidx <= '0; st <= S_ISSUE;
                end else begin
                  addr_r <= addr_r + 16'd1;
                  if (cnt_r == LEN_W'(1)) begin
                    st <= S_IDLE; done <= 1'b1; done_ok <= 1'b1;
                  end else begin
                    cnt_r <= cnt_r - 1'b1; st <= S_FETCH;
                  end
                end
              end
            endcase
          end
          S_DELAY: if (dly_exp) begin bidx <= '0; st <= S_ISSUE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  logic outst;
  int   dly_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst    <= 1'b0;
      dly_seen <= 0;
    end else begin
      if (eng_req)                outst <= 1'b1;
      else if (eng_done || abort) outst <= 1'b0;
      dly_seen <= (st == S_DELAY) ? dly_seen + 1 : 0;
    end
  end

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !eng_req);
  p_last_on_recv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_last |-> eng_op == OP_RECV);
  p_rd_after_engine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_done));
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !busy);
  p_cancel_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> done && !done_ok);
  p_fetch_then_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> eng_req && eng_op == OP_START);
  p_retry_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DELAY) && dly_exp |-> dly_seen == RETRY_DLY - 1);
endmodule

// File: tb/eeprom_xfer_seq_test.sv
`timescale 1ns/1ps
module eeprom_xfer_seq_test;
  localparam int DLY = 6;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_rd, addr_two;
  logic [6:0] cmd_dev; logic [15:0] cmd_addr; logic [15:0] cmd_len;
  logic wr_valid, wr_ready; logic [7:0] wr_data;
  logic rd_valid; logic [7:0] rd_data;
  logic cancel, busy, done, done_ok;
  logic eng_req, eng_last, eng_done, eng_ack, eng_berr;
  logic [1:0] eng_op; logic [7:0] eng_wdata, eng_rdata;

  eeprom_xfer_seq #(.LEN_W(16), .RETRY_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rd(cmd_rd), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .addr_two(addr_two), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .cancel(cancel), .busy(busy), .done(done), .done_ok(done_ok),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_last(eng_last), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_berr(eng_berr), .eng_rdata(eng_rdata)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // engine log and expectation
  logic [1:0] lg_op [256]; logic [7:0] lg_dat [256]; logic lg_last [256]; int lg_cyc [256];
  logic [1:0] ex_op [256]; logic [7:0] ex_dat [256]; logic ex_last [256];
  int lg_n = 0, ex_n = 0;
  int nack_a = -1, nack_b = -1, berr_a = -1;
  int recv_k = 0, cur_e = 0;
  logic [1:0] cur_op;
  logic [7:0] rd_buf [256];
  int rd_n = 0, done_n = 0;
  logic done_v = 1'b0;
  int wr_taken = 0;
  logic prev_rdy = 1'b0;

  function automatic logic [7:0] wpat(int i);
    return 8'(i * 37 + 5);
  endfunction
  function automatic logic [7:0] rpat(int k);
    return 8'(8'h3C + k * 13);
  endfunction

  // byte engine model
  initial begin
    eng_done = 0; eng_ack = 0; eng_berr = 0; eng_rdata = 0;
    @(negedge clk);
    forever begin
      if (eng_req) begin
        cur_e = lg_n; cur_op = eng_op;
        if (lg_n < 256) begin
          lg_op[lg_n] = eng_op; lg_dat[lg_n] = eng_wdata;
          lg_last[lg_n] = eng_last; lg_cyc[lg_n] = cyc;
        end
        lg_n++;
        if (cur_op == 2'd0) recv_k = 0;
        repeat (LAT) @(negedge clk);
        eng_ack   = !(cur_e == nack_a || cur_e == nack_b);
        eng_berr  = (cur_e == berr_a);
        eng_rdata = rpat(recv_k);
        if (cur_op == 2'd2) recv_k++;
        eng_done = 1;
        @(negedge clk);
        eng_done = 0; eng_ack = 0; eng_berr = 0;
      end else @(negedge clk);
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (done) begin done_n++; done_v = done_ok; end
    if (rd_valid) begin if (rd_n < 256) rd_buf[rd_n] = rd_data; rd_n++; end
  end

  // write stream source
  initial begin
    wr_valid = 1; wr_data = wpat(0);
    forever begin
      @(negedge clk);
      if (prev_rdy) begin wr_taken++; wr_data = wpat(wr_taken); end
      prev_rdy = wr_ready;
    end
  end

  task automatic chk(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic ex(logic [1:0] op, logic [7:0] d, logic l);
    ex_op[ex_n] = op; ex_dat[ex_n] = d; ex_last[ex_n] = l; ex_n++;
  endtask
  task automatic ex_wr(logic [6:0] dev, logic [15:0] a, logic two, logic [7:0] d, logic with_d);
    ex(2'd0, {dev, 1'b0}, 0);
    if (two) ex(2'd1, a[15:8], 0);
    ex(2'd1, a[7:0], 0);
    if (with_d) ex(2'd1, d, 0);
    ex(2'd3, 8'd0, 0);
  endtask
  task automatic ex_rd(logic [6:0] dev, int len);
    ex(2'd0, {dev, 1'b1}, 0);
    for (int k = 0; k < len; k++) ex(2'd2, 8'd0, k == len - 1);
    ex(2'd3, 8'd0, 0);
  endtask

  task automatic cmp_log(string req);
    int m;
    m = -1;
    for (int i = 0; i < ex_n && i < lg_n && i < 256; i++)
      if (m < 0 && {lg_op[i], lg_dat[i], lg_last[i]} != {ex_op[i], ex_dat[i], ex_last[i]}) m = i;
    total++;
    if (lg_n != ex_n || m >= 0) begin
      bad++;
      if (m >= 0)
        $display("FAIL %s engine log (R10 opcodes) item %0d: act=%h exp=%h (len act=%0d exp=%0d)",
                 req, m, {lg_op[m], lg_dat[m], lg_last[m]}, {ex_op[m], ex_dat[m], ex_last[m]}, lg_n, ex_n);
      else
        $display("FAIL %s engine log length: act=%0d exp=%0d", req, lg_n, ex_n);
    end
  endtask

  task automatic clear();
    lg_n = 0; ex_n = 0; rd_n = 0; done_n = 0;
    nack_a = -1; nack_b = -1; berr_a = -1;
  endtask

  task automatic issue(logic rd, logic [6:0] dev, logic [15:0] a, int len, logic two);
    @(negedge clk);
    cmd_rd = rd; cmd_dev = dev; cmd_addr = a; cmd_len = 16'(len); addr_two = two;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(string req);
    int n;
    n = 0;
    while (done_n == 0 && n < 3000) begin @(posedge clk); n++; end
    if (done_n == 0) chk(req, "done never seen", 0, 1);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; cmd_valid = 0; cmd_rd = 0; cmd_dev = 0; cmd_addr = 0;
    cmd_len = 0; addr_two = 0; cancel = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset cmd_ready", int'(cmd_ready), 1);
    chk("R1", "reset done", int'(done), 0);
    chk("R10", "reset eng_req", int'(eng_req), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // write sweep: R2 R3
    for (int two = 0; two < 2; two++)
      for (int len = 1; len <= 3; len++) begin
        clear();
        base = wr_taken;
        for (int k = 0; k < len; k++)
          ex_wr(7'h53, 16'h01FE + 16'(k), two[0], wpat(base + k), 1);
        issue(0, 7'h53, 16'h01FE, len, two[0]);
        chk("R1", "busy after accept", int'(busy), 1);
        wait_done("R3");
        chk("R3", "write result", int'(done_v), 1);
        cmp_log(two ? "R2 R3 two-byte write" : "R2 R3 one-byte write");
        chk("R3", "stream bytes used", wr_taken - base, len);
      end

    // read sweep: R2 R6
    for (int two = 0; two < 2; two++)
      for (int len = 1; len <= 3; len++) begin
        int badb;
        clear();
        ex_wr(7'h50, 16'h03FF, two[0], 8'd0, 0);
        ex_rd(7'h50, len);
        issue(1, 7'h50, 16'h03FF, len, two[0]);
        wait_done("R6");
        chk("R6", "read result", int'(done_v), 1);
        cmp_log("R2 R6 read");
        chk("R6", "read byte count", rd_n, len);
        badb = 0;
        for (int k = 0; k < len && k < rd_n; k++) if (rd_buf[k] != rpat(k)) badb++;
        chk("R6", "read bytes wrong", badb, 0);
      end

    // zero length: R1
    for (int rd = 0; rd < 2; rd++) begin
      clear();
      issue(rd[0], 7'h50, 16'h0010, 0, 0);
      @(posedge clk);
      chk("R1", "len0 done in cycle after accept", done_n, 1);
      chk("R1", "len0 pass", int'(done_v), 1);
      repeat (4) @(posedge clk);
      chk("R1", "len0 engine requests", lg_n, 0);
    end

    // single address NACK then success: R4
    clear();
    base = wr_taken;
    nack_a = 0;
    ex(2'd0, {7'h51, 1'b0}, 0); ex(2'd3, 8'd0, 0);
    ex_wr(7'h51, 16'h0005, 0, wpat(base), 1);
    issue(0, 7'h51, 16'h0005, 1, 0);
    wait_done("R4");
    chk("R4", "retry result", int'(done_v), 1);
    cmp_log("R4 retry sequence");
    chk("R4", "restart gap cycles", lg_cyc[2] - lg_cyc[1], LAT + 1 + DLY);

    // two address NACKs: R4
    clear();
    nack_a = 0; nack_b = 2;
    ex(2'd0, {7'h51, 1'b0}, 0); ex(2'd3, 8'd0, 0);
    ex(2'd0, {7'h51, 1'b0}, 0); ex(2'd3, 8'd0, 0);
    issue(0, 7'h51, 16'h0005, 2, 0);
    wait_done("R4");
    chk("R4", "second NACK fails", int'(done_v), 0);
    cmp_log("R4 double NACK");

    // data NACK: R5
    clear();
    base = wr_taken;
    nack_a = 2;
    ex(2'd0, {7'h52, 1'b0}, 0); ex(2'd1, 8'h10, 0); ex(2'd1, wpat(base), 0); ex(2'd3, 8'd0, 0);
    issue(0, 7'h52, 16'h0010, 2, 0);
    wait_done("R5");
    chk("R5", "data NACK fails", int'(done_v), 0);
    cmp_log("R5 data NACK");
    chk("R5", "stream bytes used", wr_taken - base, 1);

    // read header NACK: R7
    clear();
    nack_a = 3;
    ex_wr(7'h54, 16'h0007, 0, 8'd0, 0);
    ex(2'd0, {7'h54, 1'b1}, 0); ex(2'd3, 8'd0, 0);
    issue(1, 7'h54, 16'h0007, 2, 0);
    wait_done("R7");
    chk("R7", "read NACK fails", int'(done_v), 0);
    cmp_log("R7 read NACK");
    chk("R7", "no read bytes", rd_n, 0);

    // bus error on a send: R8
    clear();
    base = wr_taken;
    berr_a = 2;
    ex(2'd0, {7'h55, 1'b0}, 0); ex(2'd1, 8'h12, 0); ex(2'd1, 8'h34, 0);
    ex_wr(7'h55, 16'h1234, 1, wpat(base), 1);
    issue(0, 7'h55, 16'h1234, 1, 1);
    wait_done("R8");
    chk("R8", "write after bus error", int'(done_v), 1);
    cmp_log("R8 send bus error");

    // bus error on a receive: R8
    clear();
    berr_a = 4;
    ex_wr(7'h56, 16'h0020, 0, 8'd0, 0);
    ex(2'd0, {7'h56, 1'b1}, 0); ex(2'd2, 8'd0, 0);
    ex_rd(7'h56, 2);
    issue(1, 7'h56, 16'h0020, 2, 0);
    wait_done("R8");
    chk("R8", "read after bus error", int'(done_v), 1);
    cmp_log("R8 receive bus error");
    chk("R8", "read byte count", rd_n, 2);
    chk("R8", "first byte restarted", int'(rd_buf[0]), int'(rpat(0)));
    chk("R8", "second byte", int'(rd_buf[1]), int'(rpat(1)));

    // cancel while waiting: R9
    clear();
    issue(0, 7'h57, 16'h0030, 1, 0);
    while (lg_n < 2) @(negedge clk);
    @(negedge clk);
    cancel = 1;
    @(negedge clk);
    cancel = 0;
    @(posedge clk);
    chk("R9", "cancel done count", done_n, 1);
    chk("R9", "cancel result", int'(done_v), 0);
    repeat (12) @(posedge clk);
    chk("R9", "no requests after cancel", lg_n, 2);
    chk("R9", "idle after cancel", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule